// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block watches a running clock held as packed BCD bytes for hundredths, seconds, minutes, hours, day-of-week and day-of-month. It compares those values with a set of programmed alarm bytes and raises a sticky alarm flag when every selected field agrees. Software programs the alarm through a small byte-wide write port. The top bit of each alarm byte above hundredths removes that field from the match. Special values in the hundredths alarm byte choose between matching on every tick, on the units digit only, or on both hundredths digits. By clearing the masks in sequence, the repeat rate runs from every hundredth of a second to once a week (day-of-week) or once a month (date).

The comparison is made only in a cycle where the time-update strobe is high. If the match stays true, the flag is therefore set again on every strobe, not on every clock. The flag stays set until software writes a zero to it. A separate interrupt output copies the flag only when both the enable bit and the routing bit of the control byte are set.

Top module: `tod_alarm`

## Requirements
- R1: After reset, `alarm_flag_o` and `irq_o` are 0, all alarm bytes are 0 and both control bits are 0.
- R2: When the hundredths alarm byte (address 0) is 8'hFF and bit 7 is set in the bytes at addresses 1 to 4, every strobe sets the flag, whatever the time inputs are.
- R3: When the hundredths alarm byte has upper nibble 4'hF and a lower nibble 0 to 9, and all four masks are set, a strobe sets the flag only if the lower nibble of `hund_i` equals that nibble.
- R4: When the hundredths alarm byte holds two BCD digits and all masks are set, a strobe sets the flag only if `hund_i` equals the whole byte.
- R5: With bit 7 of the seconds alarm byte (address 1) clear, bits 6:0 of `sec_i` must also equal bits 6:0 of that byte.
- R6: With bit 7 of the minutes alarm byte (address 2) clear, bits 6:0 of the minutes must also match. With bit 7 of the hours alarm byte (address 3) clear, bits 5:0 of the hours must also match. Bit 6 of the hours (12/24 mode) is not compared.
- R7: With bit 7 of the day/date alarm byte (address 4) clear, bits 5:0 of that byte are compared with `mday_i[5:0]` when its bit 6 is 0, and with `wday_i[5:0]` when its bit 6 is 1.
- R8: The flag is set only at the clock edge that closes a cycle with `tick_i` high. A match with no strobe leaves the flag unchanged.
- R9: The flag stays set until a write to address 6 with data bit 0 equal to 0. A write to address 6 with bit 0 equal to 1 has no effect.
- R10: If a strobe with a match and a clearing write fall in the same cycle, the flag ends up set.
- R11: `irq_o` is 1 exactly when the flag is set and control byte (address 5) bits 0 (enable) and 1 (route) are both 1.
- R12: A strobe in the same cycle as a write to an alarm byte is compared against the value the byte held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-update strobe |
| hund_i | input | 8 | Current hundredths, BCD |
| sec_i | input | 8 | Current seconds, BCD |
| min_i | input | 8 | Current minutes, BCD |
| hour_i | input | 8 | Current hours, BCD; bit 6 is the mode bit |
| wday_i | input | 8 | Current day-of-week |
| mday_i | input | 8 | Current day-of-month, BCD |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| alarm_flag_o | output | 1 | Sticky alarm flag |
| irq_o | output | 1 | Gated alarm interrupt |

## Verification
Two events can land in one cycle: a strobe whose inputs match the alarm, and a software write that either clears the flag or reprograms an alarm byte. The bench drives `tick_i` and the write port at the same falling edge. It then reads the flag at the next falling edge. It expects the flag to be set when clear and set coincide, and cleared when the strobe in that cycle does not match. For a reprogramming write in the same cycle, it expects the match to use the alarm value from before the write. A second strobe after that cycle confirms that the new value has taken effect.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned ADDR_W  = 3;
    localparam int unsigned N_FIELD = 4;   // sec, min, hour, day/date
    localparam int unsigned FLD_W   = 7;

    typedef enum logic [ADDR_W-1:0] {
        RA_HUND  = 3'd0,
        RA_SEC   = 3'd1,
        RA_MIN   = 3'd2,
        RA_HOUR  = 3'd3,
        RA_DDATE = 3'd4,
        RA_CTRL  = 3'd5,
        RA_STAT  = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hund;
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] ddate;
        logic              irq_en;
        logic              irq_route;
        logic              flag;
    } alarm_regs_t;
endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
    import tod_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              tick_i,
    input  logic              hit_i,
    output alarm_regs_t       regs_o
);
    alarm_regs_t regs_d, regs_q;
    logic        clr_req;

    always_comb begin
        regs_d  = regs_q;
        clr_req = 1'b0;
        if (wr_en_i) begin
            case (reg_addr_e'(wr_addr_i))
                RA_HUND:  regs_d.hund  = wr_data_i;
                RA_SEC:   regs_d.sec   = wr_data_i;
                RA_MIN:   regs_d.min   = wr_data_i;
                RA_HOUR:  regs_d.hour  = wr_data_i;
                RA_DDATE: regs_d.ddate = wr_data_i;
                RA_CTRL: begin
                    regs_d.irq_en    = wr_data_i[0];
                    regs_d.irq_route = wr_data_i[1];
                end
                RA_STAT: begin
                    if (!wr_data_i[0]) begin
                        regs_d.flag = 1'b0;
                        clr_req     = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        // a match on the strobe wins over a clearing write
        if (tick_i && hit_i) regs_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs_o = regs_q;

    p_set_needs_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(regs_q.flag) |-> $past(tick_i && hit_i));
    p_hit_sets_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && hit_i) |=> regs_q.flag);
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.flag && !clr_req) |=> regs_q.flag);
    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !(tick_i && hit_i)) |=> !regs_q.flag);
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
    import tod_alarm_pkg::*;
(
    input  alarm_regs_t       regs_i,
    input  logic [BYTE_W-1:0] hund_i,
    input  logic [BYTE_W-1:0] sec_i,
    input  logic [BYTE_W-1:0] min_i,
    input  logic [BYTE_W-1:0] hour_i,
    input  logic [BYTE_W-1:0] wday_i,
    input  logic [BYTE_W-1:0] mday_i,
    output logic              hit_o
);
    localparam logic [FLD_W-1:0] W_SEC  = 7'h7F;
    localparam logic [FLD_W-1:0] W_HOUR = 7'h3F;

    logic [N_FIELD-1:0][FLD_W-1:0] alm_fld, cur_fld, width_msk;
    logic [N_FIELD-1:0]            fld_mask, fld_ok;
    logic [BYTE_W-1:0]             cal_sel;
    logic                          every_tick, units_only, hund_ok;

    always_comb begin
        cal_sel     = regs_i.ddate[6] ? wday_i : mday_i;
        alm_fld[0]  = regs_i.sec[FLD_W-1:0];   cur_fld[0] = sec_i[FLD_W-1:0];
        alm_fld[1]  = regs_i.min[FLD_W-1:0];   cur_fld[1] = min_i[FLD_W-1:0];
        alm_fld[2]  = regs_i.hour[FLD_W-1:0];  cur_fld[2] = hour_i[FLD_W-1:0];
        alm_fld[3]  = regs_i.ddate[FLD_W-1:0]; cur_fld[3] = cal_sel[FLD_W-1:0];
        width_msk[0] = W_SEC;
        width_msk[1] = W_SEC;
        width_msk[2] = W_HOUR;
        width_msk[3] = W_HOUR;
        fld_mask    = {regs_i.ddate[7], regs_i.hour[7], regs_i.min[7], regs_i.sec[7]};
    end

    for (genvar gi = 0; gi < N_FIELD; gi++) begin : g_fld
        assign fld_ok[gi] = fld_mask[gi] |
            ((alm_fld[gi] & width_msk[gi]) == (cur_fld[gi] & width_msk[gi]));
    end

    always_comb begin
        every_tick = (regs_i.hund == 8'hFF);
        units_only = (regs_i.hund[7:4] == 4'hF) && !every_tick;
        if (every_tick)      hund_ok = 1'b1;
        else if (units_only) hund_ok = (regs_i.hund[3:0] == hund_i[3:0]);
        else                 hund_ok = (regs_i.hund == hund_i);
        hit_o = hund_ok && (&fld_ok);
    end
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
    import tod_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [BYTE_W-1:0] hund_i,
    input  logic [BYTE_W-1:0] sec_i,
    input  logic [BYTE_W-1:0] min_i,
    input  logic [BYTE_W-1:0] hour_i,
    input  logic [BYTE_W-1:0] wday_i,
    input  logic [BYTE_W-1:0] mday_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic              alarm_flag_o,
    output logic              irq_o
);
    alarm_regs_t regs;
    logic        hit;

    tod_alarm_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .tick_i    (tick_i),
        .hit_i     (hit),
        .regs_o    (regs)
    );

    tod_alarm_match u_match (
        .regs_i (regs),
        .hund_i (hund_i),
        .sec_i  (sec_i),
        .min_i  (min_i),
        .hour_i (hour_i),
        .wday_i (wday_i),
        .mday_i (mday_i),
        .hit_o  (hit)
    );

    assign alarm_flag_o = regs.flag;
    assign irq_o        = regs.flag & regs.irq_en & regs.irq_route;

    p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> alarm_flag_o);
endmodule

// File: tb/tod_alarm_bench.sv
module tod_alarm_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [7:0] hund_i = '0, sec_i = '0, min_i = '0, hour_i = '0, wday_i = '0, mday_i = '0;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic       alarm_flag_o, irq_o;
    int         total = 0, bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    tod_alarm u_tod_alarm (.*);

    typedef struct packed {
        logic [7:0] ah, as, am, ahr, add;
        logic [7:0] ch, cs, cm, chr, cdy, cdt;
        logic       exp;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{8'hFF,8'h80,8'h80,8'h80,8'h80, 8'h37,8'h12,8'h44,8'h09,8'd2,8'h19, 1'b1, 8'd2}, // R2
        '{8'hFF,8'h80,8'h80,8'h80,8'h80, 8'h00,8'h00,8'h00,8'h00,8'd1,8'h01, 1'b1, 8'd2}, // R2
        '{8'hF5,8'h80,8'h80,8'h80,8'h80, 8'h35,8'h00,8'h00,8'h00,8'd1,8'h01, 1'b1, 8'd3}, // R3
        '{8'hF5,8'h80,8'h80,8'h80,8'h80, 8'h95,8'h59,8'h00,8'h00,8'd1,8'h01, 1'b1, 8'd3}, // R3
        '{8'hF5,8'h80,8'h80,8'h80,8'h80, 8'h36,8'h00,8'h00,8'h00,8'd1,8'h01, 1'b0, 8'd3}, // R3
        '{8'h42,8'h80,8'h80,8'h80,8'h80, 8'h42,8'h00,8'h00,8'h00,8'd1,8'h01, 1'b1, 8'd4}, // R4
        '{8'h42,8'h80,8'h80,8'h80,8'h80, 8'h41,8'h00,8'h00,8'h00,8'd1,8'h01, 1'b0, 8'd4}, // R4
        '{8'h42,8'h80,8'h80,8'h80,8'h80, 8'h52,8'h00,8'h00,8'h00,8'd1,8'h01, 1'b0, 8'd4}, // R4
        '{8'h10,8'h25,8'h80,8'h80,8'h80, 8'h10,8'h25,8'h00,8'h00,8'd1,8'h01, 1'b1, 8'd5}, // R5
        '{8'h10,8'h25,8'h80,8'h80,8'h80, 8'h10,8'h26,8'h00,8'h00,8'd1,8'h01, 1'b0, 8'd5}, // R5
        '{8'h10,8'h25,8'h80,8'h80,8'h80, 8'h11,8'h25,8'h00,8'h00,8'd1,8'h01, 1'b0, 8'd5}, // R5
        '{8'h00,8'h00,8'h30,8'h80,8'h80, 8'h00,8'h00,8'h30,8'h07,8'd1,8'h01, 1'b1, 8'd6}, // R6
        '{8'h00,8'h00,8'h30,8'h80,8'h80, 8'h00,8'h00,8'h31,8'h07,8'd1,8'h01, 1'b0, 8'd6}, // R6
        '{8'h00,8'h00,8'h30,8'h11,8'h80, 8'h00,8'h00,8'h30,8'h11,8'd1,8'h01, 1'b1, 8'd6}, // R6
        '{8'h00,8'h00,8'h30,8'h51,8'h80, 8'h00,8'h00,8'h30,8'h11,8'd1,8'h01, 1'b1, 8'd6}, // R6
        '{8'h00,8'h00,8'h30,8'h11,8'h80, 8'h00,8'h00,8'h30,8'h12,8'd1,8'h01, 1'b0, 8'd6}, // R6
        '{8'h00,8'h00,8'h00,8'h00,8'h15, 8'h00,8'h00,8'h00,8'h00,8'd3,8'h15, 1'b1, 8'd7}, // R7
        '{8'h00,8'h00,8'h00,8'h00,8'h15, 8'h00,8'h00,8'h00,8'h00,8'd3,8'h16, 1'b0, 8'd7}, // R7
        '{8'h00,8'h00,8'h00,8'h00,8'h43, 8'h00,8'h00,8'h00,8'h00,8'd3,8'h20, 1'b1, 8'd7}, // R7
        '{8'h00,8'h00,8'h00,8'h00,8'h43, 8'h00,8'h00,8'h00,8'h00,8'd4,8'h03, 1'b0, 8'd7}  // R7
    };

    task automatic check(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] h, s, m, hr, dy, dt);
        hund_i = h; sec_i = s; min_i = m; hour_i = hr; wday_i = dy; mday_i = dt;
    endtask

    task automatic strobe();
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(alarm_flag_o, 1'b0, "R1 flag");
        check(irq_o, 1'b0, "R1 irq");

        for (int i = 0; i < NV; i++) begin
            wr(3'd0, VEC[i].ah); wr(3'd1, VEC[i].as); wr(3'd2, VEC[i].am);
            wr(3'd3, VEC[i].ahr); wr(3'd4, VEC[i].add); wr(3'd6, 8'h00);
            set_time(VEC[i].ch, VEC[i].cs, VEC[i].cm, VEC[i].chr, VEC[i].cdy, VEC[i].cdt);
            strobe();
            check(alarm_flag_o, VEC[i].exp, $sformatf("R%0d vec%0d", VEC[i].req, i));
        end

        // R8: matching time but no strobe
        wr(3'd0, 8'hFF); wr(3'd1, 8'h80); wr(3'd2, 8'h80); wr(3'd3, 8'h80); wr(3'd4, 8'h80);
        wr(3'd6, 8'h00);
        repeat (5) @(negedge clk);
        check(alarm_flag_o, 1'b0, "R8 no strobe");
        strobe();
        check(alarm_flag_o, 1'b1, "R8 strobe sets");

        // R9: sticky, write of 1 ignored, write of 0 clears
        repeat (4) @(negedge clk);
        check(alarm_flag_o, 1'b1, "R9 held");
        wr(3'd6, 8'h01);
        check(alarm_flag_o, 1'b1, "R9 write one ignored");
        wr(3'd6, 8'h00);
        check(alarm_flag_o, 1'b0, "R9 cleared");

        // R11: interrupt gating
        strobe();
        wr(3'd5, 8'h00); check(irq_o, 1'b0, "R11 ctrl=0");
        wr(3'd5, 8'h01); check(irq_o, 1'b0, "R11 enable only");
        wr(3'd5, 8'h02); check(irq_o, 1'b0, "R11 route only");
        wr(3'd5, 8'h03); check(irq_o, 1'b1, "R11 both");
        wr(3'd6, 8'h00); check(irq_o, 1'b0, "R11 flag clear");

        // R10: clear and matching strobe in one cycle
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 3'd6; wr_data_i = 8'h00; tick_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; tick_i = 1'b0;
        check(alarm_flag_o, 1'b1, "R10 set wins");
        // clear with a non-matching strobe in one cycle
        wr(3'd0, 8'h42); set_time(8'h41, 0, 0, 0, 1, 1);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 3'd6; wr_data_i = 8'h00; tick_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; tick_i = 1'b0;
        check(alarm_flag_o, 1'b0, "R10 clear without match");

        // R12: strobe while reprogramming uses the old byte
        set_time(8'h42, 0, 0, 0, 1, 1);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = 3'd0; wr_data_i = 8'h11; tick_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; tick_i = 1'b0;
        check(alarm_flag_o, 1'b1, "R12 old value used");
        wr(3'd6, 8'h00);
        strobe();
        check(alarm_flag_o, 1'b0, "R12 new value later");

        // R1: reset again clears flag and control
        wr(3'd0, 8'hFF); strobe(); wr(3'd5, 8'h03);
        rst_n = 1'b0;
        @(negedge clk);
        check(alarm_flag_o, 1'b0, "R1 flag after reset");
        check(irq_o, 1'b0, "R1 irq after reset");
        rst_n = 1'b1;
        // alarm bytes back to 0: hundredths must match 00 and every field 0
        set_time(8'h05, 0, 0, 0, 0, 0);
        strobe();
        check(alarm_flag_o, 1'b0, "R1 alarm bytes zero");
        set_time(8'h00, 0, 0, 0, 0, 0);
        strobe();
        check(alarm_flag_o, 1'b1, "R1 zero alarm matches zero time");
        check(irq_o, 1'b0, "R1 control zero");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule